// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer with a lower and an upper bound on its service interval. It runs from the system clock and is controlled through a single 8-bit control register on a simple address/write/read port. The register holds an enable bit and two select fields. One field picks the timeout length and the other picks the earliest count at which a service is allowed. Each select field encodes a power of two.

Once enabled, an internal counter advances every clock. Software services the watchdog by writing the control register. Any write while the block is enabled counts as a service, even one that rewrites the same value. A service restarts the counter. If it lands before the minimum-clear count, it is a fault. If no service arrives before the timeout count, that is also a fault. Each fault produces a one-cycle interrupt pulse and sets a sticky status bit, which software clears by writing 1 to it. Software should set the enable bit in its final setup write, because later changes to the register are themselves service writes.

Top module: `wdog_window`

## Requirements
- R1: After reset the enable, both select fields and the status bit are zero, `wdt_irq` is low and a read of the control address returns 0x00.
- R2: Timeout select code t (bits 2:1) gives a limit of 2^(TMO_BASE+2t) clocks: 2^16, 2^18, 2^20 and 2^22 at the defaults. With no service, `wdt_irq` first goes high on exactly the 2^(TMO_BASE+2t)-th clock edge after the enabling write's edge.
- R3: Minimum-clear select code c (bits 5:3) gives a lower bound of 2^(CLR_BASE+c) clocks for c from 0 to 6 (2^7 to 2^13 at the defaults). Code 7 removes the lower bound.
- R4: A service write on the k-th edge after the counter last restarted is early, and raises `wdt_irq` on that edge, when k is at most the lower bound. A service write with k greater than the lower bound raises nothing.
- R5: Any write to the control address while the enable bit is 1 is a service event that restarts the counter. The next timeout fires 2^(TMO_BASE+2t) edges after that write.
- R6: After any fault the counter restarts from zero. A watchdog left unserviced faults again after another full timeout period.
- R7: Each fault gives a `wdt_irq` pulse one cycle wide and sets status bit 7. Writing 1 to bit 7 clears the status bit, and writing 0 there leaves it set. A fault in the same cycle as a clearing write wins.
- R8: While the enable bit is 0, the counter stays at zero and `wdt_irq` stays low. A write that sets the enable bit starts counting from zero.
- R9: A read of the control address returns {status, 0, min-clear code, timeout code, enable} in bits 7..0 on `bus_rdata` one cycle after the request. A read of any other address returns 0x00. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wdt_irq | output | 1 | One-cycle watchdog fault pulse |

## Verification
The assertions assume that the control fields change only through write strobes on the port. They also assume the minimum-clear base is no larger than the timeout base, so that every lower bound fits in the counter. The stimulus issues one request per task call and returns both strobes to low between requests. It never changes a select field except through a full register write. It uses a small base configuration so that every timeout code and every minimum-clear code can be swept to its exact edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic       sts;
    logic [2:0] csel;
    logic [1:0] tsel;
    logic       en;
  } wdog_ctl_t;

  localparam logic [2:0] CSEL_NO_BOUND = 3'd7;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              fault,
  output wdog_ctl_t         ctl,
  output logic              wr_hit,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTL_ADDR);

  logic rd_hit;
  assign wr_hit = bus_wr && (bus_addr == HIT_ADDR);
  assign rd_hit = bus_rd && (bus_addr == HIT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      bus_rdata <= 8'h00;
    end else begin
      if (wr_hit) begin
        ctl.en   <= bus_wdata[0];
        ctl.tsel <= bus_wdata[2:1];
        ctl.csel <= bus_wdata[5:3];
      end
      if (fault)
        ctl.sts <= 1'b1;
      else if (wr_hit && bus_wdata[7])
        ctl.sts <= 1'b0;
      bus_rdata <= rd_hit ? {ctl.sts, 1'b0, ctl.csel, ctl.tsel, ctl.en} : 8'h00;
    end
  end

  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> ctl.sts);
  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> bus_rdata == 8'h00);
  // R9
  foreign_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ctl.en == $past(ctl.en) && ctl.tsel == $past(ctl.tsel)
                && ctl.csel == $past(ctl.csel));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int TMO_BASE = 16,
  parameter int CLR_BASE = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] tsel,
  input  logic [2:0] csel,
  input  logic       svc,
  output logic       fault,
  output logic       irq
);
  localparam int CNT_W = TMO_BASE + 6;
  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [LIM_W-1:0] cnt_x, tmo_lim, clr_lim;
  logic             no_bound, early, expire;

  always_comb begin
    tmo_lim  = LIM_W'(1) << (TMO_BASE + 2 * int'(tsel));
    clr_lim  = LIM_W'(1) << (CLR_BASE + int'(csel));
    no_bound = (csel == CSEL_NO_BOUND);
    cnt_x    = {1'b0, cnt};
    early    = svc && !no_bound && (cnt_x < clr_lim);
    expire   = en && !svc && (cnt_x == tmo_lim - LIM_W'(1));
    fault    = early || expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= fault;
      if (!en || svc || expire)
        cnt <= '0;
      else
        cnt <= cnt + CNT_W'(1);
    end
  end

  // R8
  held_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> cnt_x < tmo_lim);
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> cnt == '0);
  // R8
  irq_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en));
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 2,
  parameter int TMO_BASE = 16,
  parameter int CLR_BASE = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_irq
);
  wdog_ctl_t ctl;
  logic      wr_hit, svc, fault;

  assign svc = wr_hit && ctl.en;

  wdog_regs #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .fault(fault),
    .ctl(ctl), .wr_hit(wr_hit), .bus_rdata(bus_rdata)
  );

  wdog_core #(.TMO_BASE(TMO_BASE), .CLR_BASE(CLR_BASE)) u_core (
    .clk(clk), .rst(rst), .en(ctl.en), .tsel(ctl.tsel), .csel(ctl.csel),
    .svc(svc), .fault(fault), .irq(wdt_irq)
  );

  // R7
  irq_sts_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |-> ctl.sts);
endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
  localparam int AW = 4;
  localparam int CA = 2;
  localparam int TB = 4;
  localparam int CB = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic          wdt_irq;
  int            checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdog_window #(.ADDR_W(AW), .CTL_ADDR(CA), .TMO_BASE(TB), .CLR_BASE(CB)) u_wdog_window (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic time_to_irq(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #1;
      n++;
      if (wdt_irq) break;
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, lim, k;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 irq", int'(wdt_irq), 0);
    rd(CA, d);
    chk("R1 read", int'(d), 0);

    // R8: disabled stays quiet, enabling starts from zero
    wr(CA, 8'h00);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (wdt_irq) n++;
    end
    chk("R8 no irq while disabled", n, 0);

    // R2 and R6: every timeout code, two periods each
    for (int t = 0; t < 4; t++) begin
      lim = 1 << (TB + 2 * t);
      wr(CA, {2'b00, 3'd7, 2'(t), 1'b1});
      time_to_irq(n);
      chk("R2 timeout edge", n, lim);
      @(posedge clk); #1;
      chk("R7 pulse width", int'(wdt_irq), 0);
      time_to_irq(n);
      chk("R6 second period", n, lim - 1);
      rd(CA, d);
      chk("R7 status set", int'(d[7]), 1);
      chk("R9 field layout", int'(d[6:0]), (7 << 3) | (t << 1) | 1);
      wr(CA, 8'h00);
      wr(CA, 8'h80);
    end

    // R3 and R4: every minimum-clear code with timeout code 3
    for (int c = 0; c < 8; c++) begin
      lim = 1 << (CB + c);
      k = (c == 7) ? 1 : lim;
      wr(CA, {2'b00, 3'(c), 2'b11, 1'b1});
      repeat (k - 1) @(posedge clk);
      wr(CA, {2'b00, 3'(c), 2'b11, 1'b1});
      chk(c == 7 ? "R3 code 7 no bound" : "R4 early at bound", int'(wdt_irq), c == 7 ? 0 : 1);
      if (c != 7) begin
        wr(CA, 8'h00);
        wr(CA, 8'h80);
        wr(CA, {2'b00, 3'(c), 2'b11, 1'b1});
        repeat (lim) @(posedge clk);
        wr(CA, {2'b00, 3'(c), 2'b11, 1'b1});
        chk("R4 valid after bound", int'(wdt_irq), 0);
        rd(CA, d);
        chk("R3 status clean", int'(d[7]), 0);
      end
      wr(CA, 8'h00);
      wr(CA, 8'h80);
    end

    // R5: a valid service restarts the timeout
    wr(CA, 8'h01);
    repeat (4) @(posedge clk);
    wr(CA, 8'h01);
    chk("R5 service no irq", int'(wdt_irq), 0);
    time_to_irq(n);
    chk("R5 timeout from service", n, 16);

    // R7: writing 0 keeps status, writing 1 clears it
    wr(CA, 8'h00);
    rd(CA, d);
    chk("R7 write 0 keeps status", int'(d[7]), 1);
    wr(CA, 8'h80);
    rd(CA, d);
    chk("R7 write 1 clears", int'(d), 0);

    // R9: foreign address ignored
    wr(CA + 1, 8'h01);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (wdt_irq) n++;
    end
    chk("R9 foreign write ignored", n, 0);
    rd(CA, d);
    chk("R9 control unchanged", int'(d), 0);
    wr(CA, 8'h2B);
    rd(CA + 1, d);
    chk("R9 foreign read zero", int'(d), 0);
    rd(CA, d);
    chk("R9 readback", int'(d), 8'h2B);
    wr(CA, 8'h00);
    wr(CA, 8'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule